// File: doc/BRIEF.md
# Unlock-Cycle Flash Bank Erase and Program Sequencer

This block runs a complete erase or program pass over one bank of a byte-wide flash device that only accepts commands after a two-write unlock preamble. A single start request selects the operation and the bank base address. For an erase, the block issues the sector-erase command chain. For a program, it fetches each source byte through a request/acknowledge port and programs the bank in ascending order. It then waits for the device to finish by toggle polling: it reads the base address twice, back to back, and repeats until the two values agree.

Once every operation completes, or after a poll gives up, the block writes the device reset command at the bank base. It then verifies the bank by reading it back. An erased bank must read all-ones. A programmed bank must match the source bytes, which the block fetches again through the same port. The block reports the result as a one-cycle completion pulse and an error level. Command offsets are added to the bank base input, so one instance can serve either of two banks.

Top module: `unlock_flash_seq`

## Requirements
- R1: Every command chain opens with 0xAA written to base+0x555 and then 0x55 written to base+0x2AA; all addresses are base plus offset modulo 2^ADDR_W.
- R2: An erase (op_prog_i=0) writes, after the opening pair, 0x80 to base+0x555, 0xAA to base+0x555, 0x55 to base+0x2AA and finally 0x30 to base, then polls once.
- R3: A program (op_prog_i=1) handles bytes in ascending index. For each byte it first fetches the source byte: src_req_o stays high with a steady src_idx_o until src_ack_i, and src_data_i is taken in that cycle. It then writes the opening pair, 0xA0 to base+0x555, and the byte to base+index, and then polls.
- R4: Between any two flash writes there are at least GAP_CYCLES cycles with no write.
- R5: A poll attempt is two consecutive read strobes at the base, with read data returned in the cycle after each strobe. The attempt succeeds when the two values are equal and is repeated otherwise; a read and a write are never strobed together.
- R6: After POLL_LIMIT failed attempts the poll ends with a timeout, which sets the error. A program timeout skips all bytes not yet written.
- R7: Every operation, including one that timed out, writes 0xF0 to the base before verification and completion.
- R8: Verification reads indices upward from 0. Erase expects 0xFF; program expects the re-fetched source byte. Verification stops at the first mismatch, which sets the error.
- R9: busy_o is high from the cycle after an accepted start until completion. done_o is a single-cycle pulse, and err_o is valid while done_o is high.
- R10: A start request while busy has no effect on the bus sequence or the target bank.
- R11: After reset the block is idle: no bus strobes, no source request, busy_o and done_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, taken only when idle |
| op_prog_i | input | 1 | 1 = program, 0 = erase |
| bank_base_i | input | ADDR_W | Base address of the target bank |
| src_req_o | output | 1 | Request for one source byte |
| src_idx_o | output | clog2(BANK_BYTES) | Index of the requested source byte |
| src_ack_i | input | 1 | Source byte present on src_data_i |
| src_data_i | input | 8 | Source byte |
| fl_we_o | output | 1 | Flash write strobe |
| fl_re_o | output | 1 | Flash read strobe |
| fl_addr_o | output | ADDR_W | Flash address |
| fl_wdata_o | output | 8 | Flash write data |
| fl_rdata_i | input | 8 | Flash read data, valid the cycle after fl_re_o |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Timeout or verify mismatch, valid with done_o |

## Verification
The assertions assume a source port that eventually acknowledges a held request, and a flash whose read data arrives exactly one cycle after the strobe. The bench's device stub and source responder are built to that contract. The responder deliberately delays each acknowledge by two cycles, which exercises the hold rule. The stub returns a toggling bit while busy, and it can stall forever or drop one program write. That lets the bench reach both the timeout path and the verify mismatch path while staying within those input assumptions.

// File: rtl/ucs_pkg.sv
package ucs_pkg;

    typedef enum logic [3:0] {
        S_IDLE, S_FETCH, S_CMD, S_GAP, S_POLL,
        S_RESET, S_VFETCH, S_VREAD, S_VCMP, S_DONE
    } seq_state_e;

    typedef enum logic [1:0] {P_IDLE, P_RD1, P_RD2, P_CMP} poll_state_e;

    localparam logic [7:0]  BYTE_UNLK1       = 8'hAA;
    localparam logic [7:0]  BYTE_UNLK2       = 8'h55;
    localparam logic [7:0]  BYTE_ERASE_SETUP = 8'h80;
    localparam logic [7:0]  BYTE_SECTOR      = 8'h30;
    localparam logic [7:0]  BYTE_PROG        = 8'hA0;
    localparam logic [7:0]  BYTE_RESET       = 8'hF0;
    localparam logic [7:0]  BYTE_BLANK       = 8'hFF;
    localparam logic [11:0] OFS_UNLK1        = 12'h555;
    localparam logic [11:0] OFS_UNLK2        = 12'h2AA;

endpackage

// File: rtl/ucs_cmd_table.sv
module ucs_cmd_table
    import ucs_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic              prog_i,
    input  logic [2:0]        step_i,
    output logic [ADDR_W-1:0] ofs_o,
    output logic [7:0]        byte_o,
    output logic              data_step_o,
    output logic              last_o
);

    // Step list: erase uses steps 0..5, program uses 0..3 (3 = data byte).
    always_comb begin
        ofs_o       = '0;
        byte_o      = BYTE_UNLK1;
        data_step_o = 1'b0;
        last_o      = 1'b0;
        case (step_i)
            3'd0: begin ofs_o = ADDR_W'(OFS_UNLK1); byte_o = BYTE_UNLK1; end
            3'd1: begin ofs_o = ADDR_W'(OFS_UNLK2); byte_o = BYTE_UNLK2; end
            3'd2: begin
                ofs_o  = ADDR_W'(OFS_UNLK1);
                byte_o = prog_i ? BYTE_PROG : BYTE_ERASE_SETUP;
            end
            3'd3: begin
                if (prog_i) begin
                    data_step_o = 1'b1;
                    last_o      = 1'b1;
                end else begin
                    ofs_o  = ADDR_W'(OFS_UNLK1);
                    byte_o = BYTE_UNLK1;
                end
            end
            3'd4: begin ofs_o = ADDR_W'(OFS_UNLK2); byte_o = BYTE_UNLK2; end
            3'd5: begin ofs_o = '0; byte_o = BYTE_SECTOR; last_o = 1'b1; end
            default: ;
        endcase
    end

endmodule

// File: rtl/ucs_toggle_poll.sv
module ucs_toggle_poll
    import ucs_pkg::*;
#(
    parameter int POLL_LIMIT = 1000000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [7:0] rdata_i,
    output logic       rd_o,
    output logic       fin_o,
    output logic       tout_o
);

    localparam int CNT_W = $clog2(POLL_LIMIT + 1);

    typedef struct packed {
        poll_state_e      st;
        logic [7:0]       first;
        logic [CNT_W-1:0] cnt;
    } poll_regs_t;

    poll_regs_t q, d;

    always_comb begin
        d      = q;
        rd_o   = 1'b0;
        fin_o  = 1'b0;
        tout_o = 1'b0;
        case (q.st)
            P_IDLE: begin
                if (start_i) begin
                    d.st  = P_RD1;
                    d.cnt = '0;
                end
            end
            P_RD1: begin
                rd_o = 1'b1;
                d.st = P_RD2;
            end
            P_RD2: begin
                rd_o    = 1'b1;
                d.first = rdata_i;
                d.st    = P_CMP;
            end
            P_CMP: begin
                if ((q.first ^ rdata_i) == 8'h00) begin
                    fin_o = 1'b1;
                    d.st  = P_IDLE;
                end else if (q.cnt == CNT_W'(POLL_LIMIT - 1)) begin
                    fin_o  = 1'b1;
                    tout_o = 1'b1;
                    d.st   = P_IDLE;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                    d.st  = P_RD1;
                end
            end
            default: d.st = P_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: P_IDLE, first: 8'h00, cnt: '0};
        else        q <= d;
    end

    // R6: the attempt counter never reaches the limit value itself
    a_r6_attempt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt < CNT_W'(POLL_LIMIT));

    // R5: every poll verdict is preceded by two consecutive reads
    a_r5_two_reads: assert property (@(posedge clk) disable iff (!rst_n)
        fin_o |-> ($past(rd_o) && $past(rd_o, 2)));

endmodule

// File: rtl/unlock_flash_seq.sv
module unlock_flash_seq
    import ucs_pkg::*;
#(
    parameter int ADDR_W     = 14,
    parameter int BANK_BYTES = 8192,
    parameter int GAP_CYCLES = 50,
    parameter int POLL_LIMIT = 1000000
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_i,
    input  logic                          op_prog_i,
    input  logic [ADDR_W-1:0]             bank_base_i,
    output logic                          src_req_o,
    output logic [$clog2(BANK_BYTES)-1:0] src_idx_o,
    input  logic                          src_ack_i,
    input  logic [7:0]                    src_data_i,
    output logic                          fl_we_o,
    output logic                          fl_re_o,
    output logic [ADDR_W-1:0]             fl_addr_o,
    output logic [7:0]                    fl_wdata_o,
    input  logic [7:0]                    fl_rdata_i,
    output logic                          busy_o,
    output logic                          done_o,
    output logic                          err_o
);

    localparam int IDX_W = $clog2(BANK_BYTES);
    localparam int GAP_W = $clog2(GAP_CYCLES + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BANK_BYTES - 1);

    typedef struct packed {
        seq_state_e        st;
        logic              prog;
        logic [ADDR_W-1:0] base;
        logic [IDX_W-1:0]  idx;
        logic [2:0]        step;
        logic [7:0]        src_byte;
        logic [GAP_W-1:0]  gap;
        logic              closing;
        logic              err;
    } seq_regs_t;

    seq_regs_t q, d;

    logic [ADDR_W-1:0] cmd_ofs;
    logic [7:0]        cmd_byte;
    logic              cmd_data_step, cmd_last;
    logic              poll_start, poll_rd, poll_fin, poll_tout;
    logic [ADDR_W-1:0] idx_addr;
    logic [7:0]        exp_byte;

    ucs_cmd_table #(.ADDR_W(ADDR_W)) i_cmd (
        .prog_i(q.prog), .step_i(q.step), .ofs_o(cmd_ofs), .byte_o(cmd_byte),
        .data_step_o(cmd_data_step), .last_o(cmd_last)
    );

    ucs_toggle_poll #(.POLL_LIMIT(POLL_LIMIT)) i_poll (
        .clk(clk), .rst_n(rst_n), .start_i(poll_start), .rdata_i(fl_rdata_i),
        .rd_o(poll_rd), .fin_o(poll_fin), .tout_o(poll_tout)
    );

    assign idx_addr = {{(ADDR_W-IDX_W){1'b0}}, q.idx};
    assign exp_byte = q.prog ? q.src_byte : BYTE_BLANK;

    always_comb begin
        d          = q;
        fl_we_o    = 1'b0;
        fl_re_o    = poll_rd;
        fl_addr_o  = q.base;
        fl_wdata_o = 8'h00;
        src_req_o  = 1'b0;
        poll_start = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (start_i) begin
                    d.prog    = op_prog_i;
                    d.base    = bank_base_i;
                    d.idx     = '0;
                    d.step    = '0;
                    d.err     = 1'b0;
                    d.closing = 1'b0;
                    d.st      = op_prog_i ? S_FETCH : S_CMD;
                end
            end
            S_FETCH: begin
                src_req_o = 1'b1;
                if (src_ack_i) begin
                    d.src_byte = src_data_i;
                    d.step     = '0;
                    d.st       = S_CMD;
                end
            end
            S_CMD: begin
                fl_we_o    = 1'b1;
                fl_addr_o  = q.base + (cmd_data_step ? idx_addr : cmd_ofs);
                fl_wdata_o = cmd_data_step ? q.src_byte : cmd_byte;
                d.gap      = GAP_W'(GAP_CYCLES);
                d.st       = S_GAP;
            end
            S_GAP: begin
                d.gap = q.gap - 1'b1;
                if (q.gap == GAP_W'(1)) begin
                    if (q.closing) begin
                        d.idx = '0;
                        d.st  = q.prog ? S_VFETCH : S_VREAD;
                    end else if (cmd_last) begin
                        poll_start = 1'b1;
                        d.st       = S_POLL;
                    end else begin
                        d.step = q.step + 1'b1;
                        d.st   = S_CMD;
                    end
                end
            end
            S_POLL: begin
                if (poll_fin) begin
                    if (poll_tout) begin
                        d.err = 1'b1;
                        d.st  = S_RESET;
                    end else if (q.prog && (q.idx != LAST_IDX)) begin
                        d.idx = q.idx + 1'b1;
                        d.st  = S_FETCH;
                    end else begin
                        d.st = S_RESET;
                    end
                end
            end
            S_RESET: begin
                fl_we_o    = 1'b1;
                fl_wdata_o = BYTE_RESET;
                d.closing  = 1'b1;
                d.gap      = GAP_W'(GAP_CYCLES);
                d.st       = S_GAP;
            end
            S_VFETCH: begin
                src_req_o = 1'b1;
                if (src_ack_i) begin
                    d.src_byte = src_data_i;
                    d.st       = S_VREAD;
                end
            end
            S_VREAD: begin
                fl_re_o   = 1'b1;
                fl_addr_o = q.base + idx_addr;
                d.st      = S_VCMP;
            end
            S_VCMP: begin
                if (fl_rdata_i != exp_byte) begin
                    d.err = 1'b1;
                    d.st  = S_DONE;
                end else if (q.idx == LAST_IDX) begin
                    d.st = S_DONE;
                end else begin
                    d.idx = q.idx + 1'b1;
                    d.st  = q.prog ? S_VFETCH : S_VREAD;
                end
            end
            S_DONE:  d.st = S_IDLE;
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: S_IDLE, prog: 1'b0, base: '0, idx: '0, step: '0,
                   src_byte: 8'h00, gap: '0, closing: 1'b0, err: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign src_idx_o = q.idx;
    assign busy_o    = (q.st != S_IDLE);
    assign done_o    = (q.st == S_DONE);
    assign err_o     = q.err;

    // Assertion support: cycles since the last write, and reset-command seen
    logic [GAP_W-1:0] since_we_q;
    logic             f0_seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_we_q <= GAP_W'(GAP_CYCLES);
            f0_seen_q  <= 1'b0;
        end else begin
            if (fl_we_o)
                since_we_q <= '0;
            else if (since_we_q != GAP_W'(GAP_CYCLES))
                since_we_q <= since_we_q + 1'b1;
            if (!busy_o && start_i)
                f0_seen_q <= 1'b0;
            else if (fl_we_o && fl_wdata_o == BYTE_RESET && fl_addr_o == q.base)
                f0_seen_q <= 1'b1;
        end
    end

    a_r4_write_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        fl_we_o |-> (since_we_q == GAP_W'(GAP_CYCLES)));

    a_r5_bus_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_we_o && fl_re_o));

    a_r3_src_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (src_req_o && !src_ack_i) |=> (src_req_o && $stable(src_idx_o)));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r7_reset_issued: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> f0_seen_q);

endmodule

// File: tb/test_unlock_flash_seq.sv
module test_unlock_flash_seq;

    localparam int CLK_PERIOD = 10;
    localparam int AW     = 14;
    localparam int BANK   = 16;
    localparam int GAP    = 3;
    localparam int LIMIT  = 8;
    localparam int IW     = $clog2(BANK);
    localparam int BUSY_N = 3;
    localparam int STALL  = 1000000;
    localparam logic [AW-1:0] BANK1 = 14'h2000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          op_prog_i = 1'b0;
    logic [AW-1:0] bank_base_i = '0;
    logic          src_req_o;
    logic [IW-1:0] src_idx_o;
    logic          src_ack_i = 1'b0;
    logic [7:0]    src_data_i = 8'h00;
    logic          fl_we_o, fl_re_o;
    logic [AW-1:0] fl_addr_o;
    logic [7:0]    fl_wdata_o;
    logic [7:0]    fl_rdata_i = 8'h00;
    logic          busy_o, done_o, err_o;

    always #(CLK_PERIOD / 2) clk = ~clk;

    unlock_flash_seq #(.ADDR_W(AW), .BANK_BYTES(BANK), .GAP_CYCLES(GAP), .POLL_LIMIT(LIMIT)) i_unlock_flash_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_prog_i(op_prog_i),
        .bank_base_i(bank_base_i), .src_req_o(src_req_o), .src_idx_o(src_idx_o),
        .src_ack_i(src_ack_i), .src_data_i(src_data_i), .fl_we_o(fl_we_o),
        .fl_re_o(fl_re_o), .fl_addr_o(fl_addr_o), .fl_wdata_o(fl_wdata_o),
        .fl_rdata_i(fl_rdata_i), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
    );

    int errors = 0;
    int checks = 0;

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] src_byte(int i);
        return 8'(i * 17) ^ 8'h5A;
    endfunction

    // Flash device stub
    logic [7:0] mem [0:16383];
    int  busy_ctr = 0;
    bit  tog = 1'b0;
    bit  prev_a0 = 1'b0;
    bit  stall_erase = 1'b0;
    int  stall_addr = -1;
    int  drop_addr = -1;

    always @(posedge clk) begin
        if (fl_re_o) begin
            if (busy_ctr > 0) begin
                fl_rdata_i <= tog ? 8'h40 : 8'h00;
                tog        <= ~tog;
                busy_ctr   <= busy_ctr - 1;
            end else begin
                fl_rdata_i <= mem[int'(fl_addr_o)];
            end
        end
        if (fl_we_o) begin
            if (prev_a0) begin
                if (int'(fl_addr_o) != drop_addr)
                    mem[int'(fl_addr_o)] <= mem[int'(fl_addr_o)] & fl_wdata_o;
                busy_ctr <= (int'(fl_addr_o) == stall_addr) ? STALL : BUSY_N;
            end else if (fl_wdata_o == 8'hF0) begin
                busy_ctr <= 0;
            end else if (fl_wdata_o == 8'h30) begin
                for (int k = 0; k < BANK; k++) mem[int'(fl_addr_o) + k] <= 8'hFF;
                busy_ctr <= stall_erase ? STALL : BUSY_N;
            end
            prev_a0 <= (fl_wdata_o == 8'hA0);
        end
    end

    // Source responder: acknowledges a held request on its third cycle
    int req_wait = 0;
    always @(negedge clk) begin
        src_data_i = src_byte(int'(src_idx_o));
        if (src_req_o) begin
            src_ack_i = (req_wait >= 2);
            req_wait++;
        end else begin
            src_ack_i = 1'b0;
            req_wait  = 0;
        end
    end

    // Reference model of the expected write stream, compared each clock
    logic [AW-1:0] qa[$];
    logic [7:0]    qd[$];
    string         qt[$];
    logic [AW-1:0] cur_base = '0;
    int since_we = 100;
    int base_reads = 0;
    int reads_since_we = 0;
    int poll_reads_at_f0 = 0;

    always @(negedge clk) begin
        logic [AW-1:0] ea;
        logic [7:0]    ed;
        string         et;
        if (rst_n) begin
            if (fl_we_o) begin
                check(since_we >= GAP, "R4", "idle cycles before write", since_we, GAP);
                if (qa.size() == 0) begin
                    check(1'b0, "R1", "unexpected write", int'(fl_addr_o), 0);
                end else begin
                    ea = qa.pop_front();
                    ed = qd.pop_front();
                    et = qt.pop_front();
                    check(fl_addr_o == ea && fl_wdata_o == ed, et, "write addr/data",
                          int'({fl_addr_o, fl_wdata_o}), int'({ea, ed}));
                end
                if (fl_wdata_o == 8'hF0 && fl_addr_o == cur_base) poll_reads_at_f0 = base_reads;
                since_we = 0;
                base_reads = 0;
                reads_since_we = 0;
            end else begin
                since_we++;
            end
            if (fl_re_o) begin
                reads_since_we++;
                if (fl_addr_o == cur_base) base_reads++;
                if (fl_we_o) check(1'b0, "R5", "read and write together", 1, 0);
            end
        end
    end

    task automatic push(logic [AW-1:0] a, logic [7:0] dt, string t);
        qa.push_back(a); qd.push_back(dt); qt.push_back(t);
    endtask

    task automatic exp_unlock(logic [AW-1:0] b);
        push(b + 14'h555, 8'hAA, "R1");
        push(b + 14'h2AA, 8'h55, "R1");
    endtask

    task automatic exp_erase(logic [AW-1:0] b);
        exp_unlock(b);
        push(b + 14'h555, 8'h80, "R2");
        push(b + 14'h555, 8'hAA, "R2");
        push(b + 14'h2AA, 8'h55, "R2");
        push(b, 8'h30, "R2");
        push(b, 8'hF0, "R7");
    endtask

    task automatic exp_prog(logic [AW-1:0] b, int n);
        for (int i = 0; i < n; i++) begin
            exp_unlock(b);
            push(b + 14'h555, 8'hA0, "R3");
            push(b + AW'(i), src_byte(i), "R3");
        end
        push(b, 8'hF0, "R7");
    endtask

    task automatic kick(bit op, logic [AW-1:0] b);
        @(negedge clk);
        start_i = 1'b1; op_prog_i = op; bank_base_i = b; cur_base = b;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, "R9", "busy after start", int'(busy_o), 1);
    endtask

    task automatic finish_op(string req, bit exp_err, int exp_vreads);
        bit ok = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (done_o) begin ok = 1'b1; break; end
        end
        check(ok, "R9", "done seen", int'(ok), 1);
        if (ok) begin
            check(err_o == exp_err, req, "err at done", int'(err_o), int'(exp_err));
            check(qa.size() == 0, "R7", "writes outstanding", qa.size(), 0);
            check(reads_since_we == exp_vreads, "R8", "verify reads", reads_since_we, exp_vreads);
            @(negedge clk);
            check(!done_o && !busy_o, "R9", "single done pulse then idle",
                  int'({done_o, busy_o}), 0);
        end
    endtask

    task automatic check_blank(logic [AW-1:0] b, string req);
        int bad = 0;
        for (int i = 0; i < BANK; i++) if (mem[int'(b) + i] != 8'hFF) bad++;
        check(bad == 0, req, "bank blank", bad, 0);
    endtask

    task automatic check_prog(logic [AW-1:0] b, int n, string req);
        int bad = 0;
        for (int i = 0; i < BANK; i++) begin
            if (i < n && mem[int'(b) + i] != src_byte(i)) bad++;
            if (i >= n && mem[int'(b) + i] != 8'hFF) bad++;
        end
        check(bad == 0, req, "bank contents", bad, 0);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            errors++;
            $display("FAIL R9 watchdog: actual=%0d expected=%0d", cyc, 150000);
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16384; i++) mem[i] = 8'hFF;
        for (int i = 0; i < BANK; i++) mem[i] = 8'(i);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !done_o && !fl_we_o && !fl_re_o && !src_req_o, "R11", "reset state",
              int'({busy_o, done_o, fl_we_o, fl_re_o, src_req_o}), 0);

        // A: erase bank 0 from garbage, with a stray start while busy (R10)
        exp_erase('0);
        kick(1'b0, '0);
        repeat (5) @(negedge clk);
        start_i = 1'b1; op_prog_i = 1'b1; bank_base_i = BANK1;
        @(negedge clk);
        start_i = 1'b0;
        finish_op("R2", 1'b0, BANK);
        check_blank('0, "R2");
        check_blank(BANK1, "R10");

        // B: erase then program bank 1
        exp_erase(BANK1);
        kick(1'b0, BANK1);
        finish_op("R2", 1'b0, BANK);
        exp_prog(BANK1, BANK);
        kick(1'b1, BANK1);
        finish_op("R3", 1'b0, BANK);
        check_prog(BANK1, BANK, "R3");

        // C: program timeout on byte 5 aborts the rest (R6)
        exp_erase('0);
        kick(1'b0, '0);
        finish_op("R2", 1'b0, BANK);
        stall_addr = 5;
        exp_prog('0, 6);
        kick(1'b1, '0);
        finish_op("R6", 1'b1, 7);
        check(poll_reads_at_f0 == 2 * LIMIT, "R6", "poll reads before timeout",
              poll_reads_at_f0, 2 * LIMIT);
        check_prog('0, 6, "R6");
        stall_addr = -1;

        // D: lost program write caught by verify, which stops there (R8)
        exp_erase('0);
        kick(1'b0, '0);
        finish_op("R2", 1'b0, BANK);
        drop_addr = 3;
        exp_prog('0, BANK);
        kick(1'b1, '0);
        finish_op("R8", 1'b1, 4);
        drop_addr = -1;

        // E: erase timeout still writes reset and verifies (R6, R7)
        stall_erase = 1'b1;
        exp_erase(BANK1);
        kick(1'b0, BANK1);
        finish_op("R6", 1'b1, BANK);
        check(poll_reads_at_f0 == 2 * LIMIT, "R6", "erase poll reads before timeout",
              poll_reads_at_f0, 2 * LIMIT);
        stall_erase = 1'b0;

        summary();
        $finish;
    end

endmodule